// File: doc/BRIEF.md
# Bucketed Video Peak Detector

This block condenses a stream of 8-bit digitized video samples into one trace point per horizontal bucket. A sweep holds a fixed number of buckets, 601 by default, indexed from zero. While a sweep runs, the block keeps a running maximum and a running minimum of the accepted samples and remembers the most recent sample. Each bucket-end strobe closes the current bucket. One cycle later the block emits a single value chosen by the detector mode, together with the bucket index.

The maximum tracker restarts after every bucket. The minimum tracker restarts only after buckets with an odd index, so each minimum spans a pair of buckets. A restarting tracker takes the next accepted sample as its new value rather than a constant. In the alternating mode, even buckets report the maximum and odd buckets report the minimum.

A sweep-start strobe arms the block, latches the detector mode and rewinds the bucket index to zero. After the last bucket, the block pulses a sweep-done flag and stays idle until the next sweep start.

Top module: `vid_bucket_reducer`

## Requirements
- R1: After reset, pt_valid, pt_value, pt_index and sweep_done are all 0, and the block is idle: bucket-end strobes and samples have no effect until the first sweep_start.
- R2: In peak-high mode (mode_sel = 0), pt_value is the largest sample accepted since the maximum tracker last restarted. A sample that coincides with the bucket-end strobe counts toward the closing bucket. The tracker restarts after every bucket and at sweep start.
- R3: In peak-low mode (mode_sel = 1), pt_value is the smallest sample accepted since the minimum tracker last restarted. That tracker restarts at sweep start and after a bucket with an odd index (index bit 0 = 1), so a minimum covers bucket 2k and bucket 2k+1.
- R4: In sampled mode (mode_sel = 2), pt_value is the last sample accepted, including a sample that coincides with the bucket-end strobe.
- R5: In alternating mode (mode_sel = 3), pt_value equals the maximum tracker for a bucket with an even index and the minimum tracker for a bucket with an odd index.
- R6: pt_valid is high for exactly the one cycle after an accepted bucket-end strobe. pt_index then carries that bucket's index, which runs 0, 1, 2 and so on within a sweep.
- R7: When bucket NUM_BUCKETS-1 closes, sweep_done is high in the same cycle as its pt_valid, for one cycle. Further bucket-end strobes produce no output until the next sweep_start.
- R8: sweep_start sets the index to 0 and makes both trackers reload from the next accepted sample. A sample or a bucket-end strobe in the same cycle as sweep_start is ignored.
- R9: mode_sel is captured only on sweep_start. Changes at any other time leave the current sweep's selection unchanged.
- R10: A tracker that has accepted no sample since its restart keeps its previous value, and a closing bucket reports that held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_start | input | 1 | Arms a new sweep and latches mode_sel |
| mode_sel | input | 2 | Detector mode: 0 peak-high, 1 peak-low, 2 sampled, 3 alternating |
| smp_valid | input | 1 | smp_data carries a sample this cycle |
| smp_data | input | 8 | Video sample |
| bkt_end | input | 1 | Closes the current bucket |
| pt_valid | output | 1 | One-cycle strobe: a trace point is ready |
| pt_value | output | 8 | Trace point value |
| pt_index | output | IDX_W | Bucket index of the trace point |
| sweep_done | output | 1 | One-cycle strobe with the final bucket's point |

## Verification
The bench builds the block with NUM_BUCKETS = 7, so it runs many complete sweeps, and the idle period after each, within a short run. Because that count is odd, the final bucket has an even index and its minimum covers only a single bucket. Sample and bucket-end densities are chosen so that empty buckets and samples coinciding with bucket ends occur often. mode_sel moves freely during sweeps, and one sweep is restarted partway through.

// File: rtl/vbr_pkg.sv
`timescale 1ns/100ps
package vbr_pkg;

    localparam int SMP_W = 8;

    typedef logic [SMP_W-1:0] smp_t;

    typedef enum logic [1:0] {
        MODE_HIGH = 2'd0,
        MODE_LOW  = 2'd1,
        MODE_SMP  = 2'd2,
        MODE_ALT  = 2'd3
    } det_mode_e;

    // Select the reported point for a closing bucket
    function automatic smp_t pick_point(det_mode_e mode, logic odd_bucket,
                                        smp_t hi, smp_t lo, smp_t last);
        smp_t r;
        case (mode)
            MODE_HIGH: r = hi;
            MODE_LOW:  r = lo;
            MODE_SMP:  r = last;
            default:   r = odd_bucket ? lo : hi;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vbr_tracker.sv
`timescale 1ns/100ps
module vbr_tracker
    import vbr_pkg::*;
#(
    parameter bit KEEP_MAX = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  smp_t smp,
    input  logic restart,
    output smp_t now_val
);
    smp_t held_q;
    logic reload_q;
    logic better;

    generate
        if (KEEP_MAX) begin : g_max
            assign better = smp > held_q;
        end else begin : g_min
            assign better = smp < held_q;
        end
    endgenerate

    // Value including a sample presented this cycle
    always_comb begin
        now_val = held_q;
        if (take && (reload_q || better)) begin
            now_val = smp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            reload_q <= 1'b1;
        end else begin
            held_q <= now_val;
            if (restart) begin
                reload_q <= 1'b1;
            end else if (take) begin
                reload_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vbr_sequencer.sv
`timescale 1ns/100ps
module vbr_sequencer
    import vbr_pkg::*;
#(
    parameter int NUM_BUCKETS = 601,
    parameter int IDX_W       = $clog2(NUM_BUCKETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sweep_start,
    input  det_mode_e        mode_in,
    input  logic             smp_valid,
    input  logic             bkt_end,
    output logic             take,
    output logic             close,
    output logic             final_bkt,
    output logic [IDX_W-1:0] idx,
    output det_mode_e        mode,
    output logic             hi_restart,
    output logic             lo_restart
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUCKETS - 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    det_mode_e        mode_q;
    logic             run;

    always_comb begin
        run        = active_q && !sweep_start;
        take       = run && smp_valid;
        close      = run && bkt_end;
        final_bkt  = (idx_q == LAST_IDX);
        hi_restart = sweep_start || close;
        lo_restart = sweep_start || (close && idx_q[0]);
        idx        = idx_q;
        mode       = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            mode_q   <= MODE_HIGH;
        end else if (sweep_start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            mode_q   <= mode_in;
        end else if (close) begin
            if (final_bkt) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vbr_emitter.sv
`timescale 1ns/100ps
module vbr_emitter
    import vbr_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  smp_t             smp,
    input  logic             close,
    input  logic             final_bkt,
    input  logic [IDX_W-1:0] idx,
    input  det_mode_e        mode,
    input  smp_t             hi_now,
    input  smp_t             lo_now,
    output logic             pt_valid,
    output smp_t             pt_value,
    output logic [IDX_W-1:0] pt_index,
    output logic             sweep_done
);
    smp_t last_q;
    smp_t last_now;

    assign last_now = take ? smp : last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q     <= '0;
            pt_valid   <= 1'b0;
            pt_value   <= '0;
            pt_index   <= '0;
            sweep_done <= 1'b0;
        end else begin
            last_q     <= last_now;
            pt_valid   <= close;
            sweep_done <= close && final_bkt;
            if (close) begin
                pt_value <= pick_point(mode, idx[0], hi_now, lo_now, last_now);
                pt_index <= idx;
            end
        end
    end
endmodule

// File: rtl/vid_bucket_reducer.sv
`timescale 1ns/100ps
module vid_bucket_reducer
    import vbr_pkg::*;
#(
    parameter int NUM_BUCKETS = 601,
    parameter int IDX_W       = $clog2(NUM_BUCKETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sweep_start,
    input  logic [1:0]       mode_sel,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             bkt_end,
    output logic             pt_valid,
    output logic [SMP_W-1:0] pt_value,
    output logic [IDX_W-1:0] pt_index,
    output logic             sweep_done
);
    logic             take;
    logic             close;
    logic             final_bkt;
    logic [IDX_W-1:0] idx;
    det_mode_e        mode;
    logic             hi_restart;
    logic             lo_restart;
    smp_t             trk_now [2];
    logic             trk_restart [2];

    vbr_sequencer #(.NUM_BUCKETS(NUM_BUCKETS), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sweep_start(sweep_start),
        .mode_in    (det_mode_e'(mode_sel)),
        .smp_valid  (smp_valid),
        .bkt_end    (bkt_end),
        .take       (take),
        .close      (close),
        .final_bkt  (final_bkt),
        .idx        (idx),
        .mode       (mode),
        .hi_restart (hi_restart),
        .lo_restart (lo_restart)
    );

    assign trk_restart[0] = hi_restart;
    assign trk_restart[1] = lo_restart;

    // Slot 0 keeps the maximum, slot 1 the minimum
    generate
        for (genvar g = 0; g < 2; g++) begin : g_trk
            vbr_tracker #(.KEEP_MAX(g == 0)) u_trk (
                .clk    (clk),
                .rst    (rst),
                .take   (take),
                .smp    (smp_data),
                .restart(trk_restart[g]),
                .now_val(trk_now[g])
            );
        end
    endgenerate

    vbr_emitter #(.IDX_W(IDX_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .smp       (smp_data),
        .close     (close),
        .final_bkt (final_bkt),
        .idx       (idx),
        .mode      (mode),
        .hi_now    (trk_now[0]),
        .lo_now    (trk_now[1]),
        .pt_valid  (pt_valid),
        .pt_value  (pt_value),
        .pt_index  (pt_index),
        .sweep_done(sweep_done)
    );
endmodule

// File: rtl/vbr_checker.sv
`timescale 1ns/100ps
module vbr_checker #(
    parameter int NUM_BUCKETS = 601,
    parameter int IDX_W       = $clog2(NUM_BUCKETS)
) (
    input logic             clk,
    input logic             rst,
    input logic             sweep_start,
    input logic             bkt_end,
    input logic             pt_valid,
    input logic [IDX_W-1:0] pt_index,
    input logic             sweep_done
);
    AST_POINT_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        pt_valid |-> $past(bkt_end)); // R6
    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pt_valid |-> (pt_index <= IDX_W'(NUM_BUCKETS - 1))); // R6
    AST_DONE_ON_FINAL: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> (pt_valid && pt_index == IDX_W'(NUM_BUCKETS - 1))); // R7
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !pt_valid); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done); // R7
    AST_START_MASKS_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        sweep_start |=> !pt_valid); // R8
endmodule

bind vid_bucket_reducer vbr_checker #(.NUM_BUCKETS(NUM_BUCKETS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sweep_start(sweep_start),
    .bkt_end    (bkt_end),
    .pt_valid   (pt_valid),
    .pt_index   (pt_index),
    .sweep_done (sweep_done)
);

// File: tb/vid_bucket_reducer_test.sv
`timescale 1ns/100ps
module vid_bucket_reducer_test;
    localparam int N     = 7;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sweep_start = 1'b0;
    logic [1:0]       mode_sel = 2'd0;
    logic             smp_valid = 1'b0;
    logic [7:0]       smp_data = 8'd0;
    logic             bkt_end = 1'b0;
    logic             pt_valid;
    logic [7:0]       pt_value;
    logic [IDX_W-1:0] pt_index;
    logic             sweep_done;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  chk_en = 1'b0;
    bit  finished = 1'b0;
    bit  started = 1'b0;

    // Reference model state
    bit  m_active;
    int  m_mode, m_idx, m_hi, m_lo, m_last;
    bit  m_hi_re, m_lo_re;
    bit  e_valid, e_done;
    int  e_val, e_idx;

    always #2.5 clk = ~clk;

    vid_bucket_reducer #(.NUM_BUCKETS(N)) uut (
        .clk(clk), .rst(rst), .sweep_start(sweep_start), .mode_sel(mode_sel),
        .smp_valid(smp_valid), .smp_data(smp_data), .bkt_end(bkt_end),
        .pt_valid(pt_valid), .pt_value(pt_value), .pt_index(pt_index),
        .sweep_done(sweep_done)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_mode = 0; m_idx = 0; m_hi = 0; m_lo = 0; m_last = 0;
            m_hi_re = 1; m_lo_re = 1; e_valid = 0; e_done = 0; e_val = 0; e_idx = 0;
        end else begin
            bit act, tk, cl;
            int hi_n, lo_n, last_n, d;
            d = int'(smp_data);
            act = m_active && !sweep_start;
            tk = act && smp_valid;
            cl = act && bkt_end;
            hi_n = m_hi; lo_n = m_lo; last_n = m_last;
            if (tk) begin
                hi_n = (m_hi_re || d > m_hi) ? d : m_hi;
                lo_n = (m_lo_re || d < m_lo) ? d : m_lo;
                last_n = d;
            end
            e_valid = cl;
            e_done = cl && (m_idx == N - 1);
            if (cl) begin
                e_idx = m_idx;
                case (m_mode)
                    0: e_val = hi_n;
                    1: e_val = lo_n;
                    2: e_val = last_n;
                    default: e_val = (m_idx % 2 == 1) ? lo_n : hi_n;
                endcase
            end
            m_hi = hi_n; m_lo = lo_n; m_last = last_n;
            if (tk) begin m_hi_re = 0; m_lo_re = 0; end
            if (cl) begin
                m_hi_re = 1;
                if (m_idx % 2 == 1) m_lo_re = 1;
                if (m_idx == N - 1) m_active = 0;
                else m_idx = m_idx + 1;
            end
            if (sweep_start) begin
                m_active = 1; m_idx = 0; m_mode = int'(mode_sel);
                m_hi_re = 1; m_lo_re = 1;
            end
        end
    end

    function automatic string val_tag(int mode);
        case (mode)
            0: return "R2 (with R8 R9 R10)";
            1: return "R3 (with R8 R9 R10)";
            2: return "R4 (with R8 R9)";
            default: return "R5 (with R8 R9 R10)";
        endcase
    endfunction

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !finished) begin
            n_vec++;
            if (pt_valid !== e_valid) begin
                n_bad++;
                $display("FAIL %s pt_valid got %0b exp %0b", started ? "R6" : "R1", pt_valid, e_valid);
            end
            if (sweep_done !== e_done) begin
                n_bad++;
                $display("FAIL R7 sweep_done got %0b exp %0b", sweep_done, e_done);
            end
            if (e_valid) begin
                if (int'(pt_index) != e_idx) begin
                    n_bad++;
                    $display("FAIL R6 pt_index got %0d exp %0d", pt_index, e_idx);
                end
                if (int'(pt_value) != e_val) begin
                    n_bad++;
                    $display("FAIL %s pt_value got %0d exp %0d", val_tag(m_mode), pt_value, e_val);
                end
            end
        end
    end

    task automatic drive(bit st, int md, bit sv, int sd, bit be);
        @(negedge clk);
        #1;
        sweep_start = st;
        mode_sel = 2'(md);
        smp_valid = sv;
        smp_data = 8'(sd);
        bkt_end = be;
    endtask

    task automatic random_cycle(int bkt_pct);
        drive(1'b0, $urandom_range(0, 3), ($urandom_range(0, 99) < 45),
              $urandom_range(0, 255), ($urandom_range(0, 99) < bkt_pct));
    endtask

    initial begin
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state checked directly
        n_vec++;
        if (pt_valid !== 1'b0 || pt_value !== 8'd0 || pt_index !== '0 || sweep_done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs got %0b/%0d/%0d/%0b exp 0/0/0/0",
                     pt_valid, pt_value, pt_index, sweep_done);
        end
        rst = 1'b0;
        chk_en = 1'b1;
        // R1: idle before first sweep start, boundaries must be ignored
        for (int i = 0; i < 12; i++) random_cycle(50);
        started = 1'b1;
        for (int s = 0; s < 24; s++) begin
            // Some starts coincide with a sample and a boundary (R8)
            drive(1'b1, s % 4, (s % 3 == 0), $urandom_range(0, 255), (s % 2 == 0));
            for (int c = 0; c < 400 && (m_active || c == 0); c++) begin
                random_cycle((s % 5 == 4) ? 70 : 25);
                if (s == 9 && c == 8) drive(1'b1, 3, 1'b1, 17, 1'b1); // R8 mid-sweep restart
            end
            // R7: boundaries after the last bucket are ignored
            for (int i = 0; i < 6; i++) random_cycle(60);
        end
        drive(1'b0, 0, 1'b0, 0, 1'b0);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule